// File: doc/BRIEF.md
# Lane Exchange Crossbar

This block lets each of 32 parallel lanes fetch a 32-bit word held by another lane in the same cycle. Every lane computes a source lane from its own lane number, a signed per-lane offset and one of four addressing modes: shift toward lower lanes, shift toward higher lanes, XOR swap, or direct index. A full crossbar then routes the selected words. The lane set can be split into equal power-of-two subsections, and each request is bounds-checked against the end of its own subsection.

A control word packs two 5-bit fields: a subsection mask and an end-lane number. A request that fails the bounds test returns the requesting lane's own input word, and its per-lane in-bounds flag is cleared. Results, flags and a valid strobe are registered and appear one clock after the input strobe. A lane participation mask is accepted at the edge but has no influence on any result.

Top module: `lane_exchange`

## Requirements
- R1: The subsection mask is taken from `in_opts[12:8]` and the end-lane number from `in_opts[4:0]`. For lane L the subsection base is `L & mask` and the subsection end is `base | (end & ~mask)` (5 bits); a mask of 32 minus width W forms W-lane subsections.
- R2: Mode encoding on `in_mode` is 0 up, 1 down, 2 xor, 3 index. In up mode the source is `L - delta`, out of range when it is less than the subsection end.
- R3: In down mode the source is `L + delta`, out of range when it is greater than the subsection end.
- R4: In xor mode the source is `L ^ delta`, out of range when it is greater than the subsection end.
- R5: In index mode the source is `(delta & ~mask) | base`, with the mask zero-extended before inversion so upper delta bits survive; it is out of range when greater than the subsection end.
- R6: The per-lane delta (`in_delta[32*L +: 32]`) is a signed 32-bit value and source arithmetic is done without wrap-around, so a huge or negative offset is judged by its true value; an in-range source selects lane `src[4:0]`.
- R7: An in-range lane outputs the selected lane's word with `out_inb` bit set; an out-of-range lane outputs its own input word with the bit cleared.
- R8: `out_valid` is `in_valid` delayed by one clock, and results of an accepted request appear in that same cycle; back-to-back requests are accepted every cycle.
- R9: While `in_valid` is low, `out_data` and `out_inb` hold their previous values whatever the other inputs do.
- R10: `in_member_mask` has no effect on any output.
- R11: Synchronous active-high `rst` clears `out_valid`, `out_data` and `out_inb` on the next clock, taking priority over `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | Addressing mode (0 up, 1 down, 2 xor, 3 index) |
| in_opts | input | 32 | Control word: mask in bits 12:8, end lane in bits 4:0 |
| in_member_mask | input | 32 | Participation mask, ignored |
| in_data | input | 1024 | Lane words, lane L at bits 32*L +: 32 |
| in_delta | input | 1024 | Signed per-lane offsets, lane L at bits 32*L +: 32 |
| out_valid | output | 1 | Result strobe, one clock after in_valid |
| out_data | output | 1024 | Exchanged lane words |
| out_inb | output | 32 | Per-lane in-bounds flags |

## Verification
The hardest situations to reach are the ones where a lane's source leaves its subsection yet still passes the bounds test, or where a large signed offset would wrap in narrow arithmetic. The stimulus table pairs narrow subsection masks with offsets that push XOR and index sources across subsection boundaries, a maximal positive down offset, a negative up offset and an XOR that sets the bit just above the lane field. Per-lane offsets are spread across lanes so that in-range and fallback lanes occur side by side in one request.

// File: rtl/lane_xchg_pkg.sv
package lane_xchg_pkg;

    localparam int unsigned XCH_LANES   = 32;
    localparam int unsigned XCH_LANE_W  = $clog2(XCH_LANES);
    localparam int unsigned XCH_DELTA_W = 32;
    localparam int unsigned XCH_IDX_W   = XCH_DELTA_W + 2;
    localparam int unsigned XCH_OPT_W   = 32;
    localparam int unsigned OPT_MASK_LSB = 8;
    localparam int unsigned OPT_END_LSB  = 0;

    typedef enum logic [1:0] {
        XM_UP    = 2'd0,
        XM_DOWN  = 2'd1,
        XM_XOR   = 2'd2,
        XM_INDEX = 2'd3
    } xchg_mode_e;

    typedef struct packed {
        logic [XCH_LANE_W-1:0] mask;
        logic [XCH_LANE_W-1:0] end_id;
    } xchg_opts_t;

    typedef struct packed {
        logic [XCH_LANE_W-1:0] src;
        logic                  inb;
    } lane_route_t;

    function automatic logic signed [XCH_IDX_W-1:0] widen_lane(input logic [XCH_LANE_W-1:0] v);
        return $signed({{(XCH_IDX_W-XCH_LANE_W){1'b0}}, v});
    endfunction

    function automatic logic signed [XCH_IDX_W-1:0] widen_delta(input logic [XCH_DELTA_W-1:0] d);
        return $signed({{(XCH_IDX_W-XCH_DELTA_W){d[XCH_DELTA_W-1]}}, d});
    endfunction

endpackage

// File: rtl/xchg_opts_decode.sv
module xchg_opts_decode
    import lane_xchg_pkg::*;
(
    input  logic [XCH_OPT_W-1:0] opts_word,
    output xchg_opts_t           opts
);
    always_comb begin
        opts.mask   = opts_word[OPT_MASK_LSB +: XCH_LANE_W];
        opts.end_id = opts_word[OPT_END_LSB  +: XCH_LANE_W];
    end
endmodule

// File: rtl/xchg_route_calc.sv
module xchg_route_calc
    import lane_xchg_pkg::*;
#(
    parameter int unsigned LANE_ID = 0
) (
    input  xchg_mode_e             mode,
    input  xchg_opts_t             opts,
    input  logic [XCH_DELTA_W-1:0] delta,
    output lane_route_t            route
);
    localparam logic [XCH_LANE_W-1:0] SELF = XCH_LANE_W'(LANE_ID);

    logic [XCH_LANE_W-1:0]         base;
    logic [XCH_LANE_W-1:0]         sub_end;
    logic signed [XCH_IDX_W-1:0]   self_x;
    logic signed [XCH_IDX_W-1:0]   end_x;
    logic signed [XCH_IDX_W-1:0]   base_x;
    logic signed [XCH_IDX_W-1:0]   keep_x;
    logic signed [XCH_IDX_W-1:0]   delta_x;
    logic signed [XCH_IDX_W-1:0]   idx;
    logic                          oob;

    always_comb begin
        base    = SELF & opts.mask;
        sub_end = base | (opts.end_id & ~opts.mask);
        self_x  = widen_lane(SELF);
        end_x   = widen_lane(sub_end);
        base_x  = widen_lane(base);
        keep_x  = ~widen_lane(opts.mask);
        delta_x = widen_delta(delta);
        case (mode)
            XM_UP: begin
                idx = self_x - delta_x;
                oob = (idx < end_x);
            end
            XM_DOWN: begin
                idx = self_x + delta_x;
                oob = (idx > end_x);
            end
            XM_XOR: begin
                idx = self_x ^ delta_x;
                oob = (idx > end_x);
            end
            XM_INDEX: begin
                idx = (delta_x & keep_x) | base_x;
                oob = (idx > end_x);
            end
            default: begin
                idx = self_x;
                oob = 1'b0;
            end
        endcase
        route.src = oob ? SELF : idx[XCH_LANE_W-1:0];
        route.inb = ~oob;
    end
endmodule

// File: rtl/xchg_crossbar.sv
module xchg_crossbar
    import lane_xchg_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic [XCH_LANES-1:0][DATA_W-1:0] src_data,
    input  lane_route_t [XCH_LANES-1:0]      routes,
    output logic [XCH_LANES-1:0][DATA_W-1:0] picked
);
    for (genvar g = 0; g < XCH_LANES; g++) begin : g_col
        assign picked[g] = src_data[routes[g].src];
    end
endmodule

// File: rtl/xchg_out_stage.sv
module xchg_out_stage
    import lane_xchg_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            take,
    input  logic [XCH_LANES-1:0][DATA_W-1:0] picked,
    input  lane_route_t [XCH_LANES-1:0]     routes,
    output logic                            q_valid,
    output logic [XCH_LANES*DATA_W-1:0]     q_data,
    output logic [XCH_LANES-1:0]            q_inb
);
    logic [XCH_LANES-1:0] inb_now;

    for (genvar g = 0; g < XCH_LANES; g++) begin : g_flag
        assign inb_now[g] = routes[g].inb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_data  <= '0;
            q_inb   <= '0;
        end else begin
            q_valid <= take;
            if (take) begin
                q_data <= picked;
                q_inb  <= inb_now;
            end
        end
    end

    p_valid_follows_r8: assert property (@(posedge clk) disable iff (rst)
        take |=> q_valid);
    p_valid_drops_r8: assert property (@(posedge clk) disable iff (rst)
        !take |=> !q_valid);
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !take |=> ($stable(q_data) && $stable(q_inb)));
    p_reset_clears_r11: assert property (@(posedge clk)
        rst |=> (!q_valid && q_inb == '0 && q_data == '0));
endmodule

// File: rtl/lane_exchange.sv
module lane_exchange
    import lane_xchg_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            in_valid,
    input  logic [1:0]                      in_mode,
    input  logic [XCH_OPT_W-1:0]            in_opts,
    input  logic [XCH_LANES-1:0]            in_member_mask,
    input  logic [XCH_LANES*DATA_W-1:0]     in_data,
    input  logic [XCH_LANES*XCH_DELTA_W-1:0] in_delta,
    output logic                            out_valid,
    output logic [XCH_LANES*DATA_W-1:0]     out_data,
    output logic [XCH_LANES-1:0]            out_inb
);
    xchg_opts_t                             opts;
    xchg_mode_e                             mode;
    logic [XCH_LANES-1:0][DATA_W-1:0]       lane_words;
    logic [XCH_LANES-1:0][XCH_DELTA_W-1:0]  lane_deltas;
    lane_route_t [XCH_LANES-1:0]            routes;
    logic [XCH_LANES-1:0][DATA_W-1:0]       picked;
    logic                                   unused_inputs;

    assign mode          = xchg_mode_e'(in_mode);
    assign lane_words    = in_data;
    assign lane_deltas   = in_delta;
    assign unused_inputs = ^{in_member_mask,
                             in_opts[XCH_OPT_W-1:OPT_MASK_LSB+XCH_LANE_W],
                             in_opts[OPT_MASK_LSB-1:OPT_END_LSB+XCH_LANE_W]};

    xchg_opts_decode u_opts (
        .opts_word (in_opts),
        .opts      (opts)
    );

    for (genvar g = 0; g < XCH_LANES; g++) begin : g_lane
        xchg_route_calc #(.LANE_ID(g)) u_route (
            .mode  (mode),
            .opts  (opts),
            .delta (lane_deltas[g]),
            .route (routes[g])
        );
    end

    xchg_crossbar #(.DATA_W(DATA_W)) u_xbar (
        .src_data (lane_words),
        .routes   (routes),
        .picked   (picked)
    );

    xchg_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .take    (in_valid),
        .picked  (picked),
        .routes  (routes),
        .q_valid (out_valid),
        .q_data  (out_data),
        .q_inb   (out_inb)
    );

    for (genvar g = 0; g < XCH_LANES; g++) begin : g_chk
        p_fallback_own_r7: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (out_inb[g] ||
                          out_data[g*DATA_W +: DATA_W] == $past(in_data[g*DATA_W +: DATA_W])));
    end
endmodule

// File: tb/test_lane_exchange.sv
`timescale 1ns/1ps
module test_lane_exchange;
    localparam int L = 32;
    localparam int W = 32;
    localparam int NV = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [1:0]       in_mode = '0;
    logic [31:0]      in_opts = '0;
    logic [L-1:0]     in_mm = '1;
    logic [L*W-1:0]   in_data = '0;
    logic [L*32-1:0]  in_delta = '0;
    logic             out_valid;
    logic [L*W-1:0]   out_data;
    logic [L-1:0]     out_inb;

    logic [L*W-1:0]   exp_data;
    logic [L-1:0]     exp_inb;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    lane_exchange i_lane_exchange (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_opts(in_opts), .in_member_mask(in_mm), .in_data(in_data),
        .in_delta(in_delta), .out_valid(out_valid), .out_data(out_data),
        .out_inb(out_inb)
    );

    // {mode, opts, delta, spread}; lane delta = delta + (spread ? 3*lane : 0)
    localparam logic [66:0] VECS [0:NV-1] = '{
        {2'd0, 32'h0000_0000, 32'd1,          1'b0},  // up by one, whole set
        {2'd1, 32'h0000_001F, 32'd1,          1'b0},  // down by one
        {2'd2, 32'h0000_001F, 32'd16,         1'b0},  // xor half swap
        {2'd3, 32'h0000_001F, 32'd5,          1'b0},  // broadcast lane 5
        {2'd0, 32'h0000_1800, 32'd2,          1'b0},  // up, 8-lane subsections
        {2'd1, 32'h0000_181F, 32'd3,          1'b0},  // down, 8-lane subsections
        {2'd2, 32'h0000_1C1F, 32'd5,          1'b0},  // xor crossing 4-lane subsections
        {2'd3, 32'h0000_101F, 32'd3,          1'b1},  // index, 16-lane, upper delta bits
        {2'd1, 32'h0000_001F, 32'h7FFF_FFFF,  1'b0},  // huge down offset
        {2'd0, 32'h0000_0000, 32'hFFFF_FFFE,  1'b0},  // negative up offset
        {2'd3, 32'h0000_0007, 32'd0,          1'b1},  // index, end lane 7
        {2'd2, 32'h0000_001F, 32'd32,         1'b0}   // xor bit above lane field
    };

    function automatic string vec_tag(input int v);
        case (v)
            0, 4:      return "R2";
            1, 5:      return "R3";
            2, 6, 11:  return "R4";
            3, 7, 10:  return "R5";
            default:   return "R6";
        endcase
    endfunction

    // Reference model written from the requirements (R1..R6)
    function automatic void model_lane(input logic [1:0] m, input logic [31:0] op,
                                       input logic [31:0] dl, input int lane,
                                       output int src, output bit inb);
        longint mask, endid, base, send, d, s;
        bit oob;
        mask  = longint'(op[12:8]);
        endid = longint'(op[4:0]);
        base  = longint'(lane) & mask;
        send  = base | (endid & (31 - mask));
        d     = longint'($signed(dl));
        case (m)
            2'd0:    s = longint'(lane) - d;
            2'd1:    s = longint'(lane) + d;
            2'd2:    s = longint'(lane) ^ d;
            default: s = (d & ~mask) | base;
        endcase
        oob = (m == 2'd0) ? (s < send) : (s > send);
        src = oob ? lane : int'(s & 31);
        inb = !oob;
    endfunction

    function automatic logic [31:0] lane_word(input int v, input int lane);
        return 32'h5A00_0000 ^ (32'(v) << 16) ^ (32'(lane) * 32'h0000_0107);
    endfunction

    task automatic load_vec(input int v, input logic [31:0] mm);
        logic [1:0]  m;
        logic [31:0] op, dl, dd;
        logic        sp;
        int          src;
        bit          ok;
        {m, op, dl, sp} = VECS[v];
        in_mode = m;
        in_opts = op;
        in_mm   = mm;
        for (int i = 0; i < L; i++) begin
            dd = dl + (sp ? 32'(3 * i) : 32'd0);
            in_delta[i*32 +: 32] = dd;
            in_data[i*W +: W]    = lane_word(v, i);
        end
        for (int i = 0; i < L; i++) begin
            model_lane(m, op, in_delta[i*32 +: 32], i, src, ok);
            exp_data[i*W +: W] = in_data[src*W +: W];
            exp_inb[i]         = ok;
        end
    endtask

    task automatic check_bus(input string req, input string what,
                             input logic [L*W-1:0] act, input logic [L*W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            for (int i = 0; i < L; i++) begin
                if (act[i*W +: W] !== exp[i*W +: W]) begin
                    $display("FAIL %s %s lane %0d: actual %h expected %h",
                             req, what, i, act[i*W +: W], exp[i*W +: W]);
                    break;
                end
            end
        end
    endtask

    task automatic check32(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check32("R11", "valid in reset", 32'(out_valid), 32'd0);
        check32("R11", "flags in reset", out_inb, 32'd0);
        check_bus("R11", "data in reset", out_data, '0);
        rst = 1'b0;
        @(negedge clk);
        check32("R8", "idle valid", 32'(out_valid), 32'd0);

        // Table walk, alternating participation masks (R10)
        for (int v = 0; v < NV; v++) begin
            load_vec(v, (v % 2 == 0) ? 32'hFFFF_FFFF : 32'h0000_0000);
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check32("R8", "valid after request", 32'(out_valid), 32'd1);
            check_bus(vec_tag(v), "data", out_data, exp_data);
            check32("R7", "in-bounds flags", out_inb, exp_inb);
        end

        // R9: idle with changing inputs keeps results
        in_data  = ~in_data;
        in_mode  = 2'd2;
        in_opts  = 32'h0000_1C1F;
        @(negedge clk);
        check32("R8", "valid drops", 32'(out_valid), 32'd0);
        check_bus("R9", "held data", out_data, exp_data);
        check32("R9", "held flags", out_inb, exp_inb);

        // R10: sparse mask on the index vector gives full result
        load_vec(7, 32'h0000_0001);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_bus("R10", "data with sparse mask", out_data, exp_data);
        check32("R10", "flags with sparse mask", out_inb, exp_inb);

        // R8: back-to-back requests
        load_vec(5, 32'hFFFF_FFFF);
        in_valid = 1'b1;
        @(negedge clk);
        check_bus("R8", "first of pair", out_data, exp_data);
        load_vec(6, 32'hFFFF_FFFF);
        @(negedge clk);
        in_valid = 1'b0;
        check32("R8", "second valid", 32'(out_valid), 32'd1);
        check_bus("R8", "second of pair", out_data, exp_data);
        check32("R8", "second flags", out_inb, exp_inb);

        // R11: reset wins over a request
        load_vec(2, 32'hFFFF_FFFF);
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b0;
        check32("R11", "valid after reset", 32'(out_valid), 32'd0);
        check32("R11", "flags after reset", out_inb, 32'd0);
        check_bus("R11", "data after reset", out_data, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule